// File: doc/BRIEF.md
# Flash command sequence decoder

This block models the command interface of a byte-wide parallel NOR flash with a 19-bit address and an 8-bit data bus. It watches write bus cycles, each an address and data pair qualified by a one-cycle write strobe. Most commands are unlock sequences of address and data pairs. When a full sequence for byte program or chip erase arrives, the block sends an operation request to the array controller. It also tracks identification mode and a permanent boot-sector lock. It drives the read-data multiplexer, which returns either array data or identification bytes.

The protected window is 16K bytes. It sits at the bottom or the top of the address space, as a parameter selects. The lock blocks program requests into that window. Erase requests carry a flag that tells the array side to leave the window alone. While the array side reports busy, write cycles have no effect.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `op_valid_o`, `id_mode_o` and `boot_locked_o` are 0, and `rd_data_o` follows `arr_data_i`.
- R2: Four writes form a program request: AAh to 5555h, then 55h to 2AAAh, then A0h to 5555h, then any target. In the cycle after the target write, `op_valid_o` is 1 for exactly one cycle. In that cycle `op_kind_o` is 0 and `op_addr_o`/`op_data_o` hold the target address and data.
- R3: Chip erase is six writes: AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h. In the cycle after the last write, `op_valid_o` pulses once with `op_kind_o` = 1. At that point `op_keep_boot_o` equals the lock state.
- R4: The same six writes with 40h as the last data set `boot_locked_o` from the next cycle on. It stays 1 until reset, and no request is issued.
- R5: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode_o`. Two things clear it. One is AAh@5555h, 55h@2AAAh, F0h@5555h. The other is a single write of F0h to any address, unless the decoder is waiting for a program target.
- R6: With `id_mode_o` = 0, `rd_data_o` = `arr_data_i`. With `id_mode_o` = 1, reading address 0 gives MFR_CODE and address 1 gives DEV_CODE. Address 2 gives the lock state on bit 0 with the upper bits zero. Any other address gives 00h.
- R7: A write that does not match the next expected pair returns the decoder to idle. The remaining writes of the broken sequence then cause no request and no mode change.
- R8: A write made while `busy_i` = 1 changes nothing: no request, no mode change, no sequence progress.
- R9: Only address bits 14:0 are compared with 5555h and 2AAAh. Any value of bits 18:15 is accepted.
- R10: While locked, a program whose target lies in the boot window is dropped with no request. Programs outside the window still go through. The window is 00000h–03FFFh when TOP_BOOT = 0 and 7C000h–7FFFFh when TOP_BOOT = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one cycle per bus write |
| wr_addr_i | input | 19 | Write address |
| wr_data_i | input | 8 | Write data |
| busy_i | input | 1 | Array side is busy; writes are ignored |
| rd_addr_i | input | 19 | Read address |
| arr_data_i | input | 8 | Data read from the array |
| rd_data_o | output | 8 | Read data after the mode multiplexer |
| op_valid_o | output | 1 | One-cycle operation request |
| op_kind_o | output | 1 | 0 = byte program, 1 = chip erase |
| op_addr_o | output | 19 | Program target address |
| op_data_o | output | 8 | Program data |
| op_keep_boot_o | output | 1 | Erase must skip the boot window |
| id_mode_o | output | 1 | Identification read mode active |
| boot_locked_o | output | 1 | Boot window permanently locked |

## Verification
Some rules are checked on every cycle:
- a request lasts a single cycle;
- the lock never clears;
- a busy cycle leaves requests, mode and lock unchanged;
- a program request never targets the window while locked;
- an erase carries the lock state;
- the read multiplexer returns array data outside identification mode and the lock bit at address 2 inside it.

Other behaviour only the bench scenarios can show, because it depends on the order of whole write sequences:
- that a correct sequence produces exactly one request with the right fields;
- that a broken or busy-masked sequence produces nothing;
- that the upper address bits are ignored;
- that each way into and out of identification mode works.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_KEY1,
    ST_KEY2,
    ST_PROG,
    ST_ERA3,
    ST_ERA4,
    ST_ERA5
  } seq_state_e;

  localparam int unsigned CMD_AW = 15;
  localparam logic [CMD_AW-1:0] ADDR_KEY_A = 15'h5555;
  localparam logic [CMD_AW-1:0] ADDR_KEY_B = 15'h2AAA;

  localparam logic [7:0] D_KEY_A    = 8'hAA;
  localparam logic [7:0] D_KEY_B    = 8'h55;
  localparam logic [7:0] D_PROG     = 8'hA0;
  localparam logic [7:0] D_ERA_SET  = 8'h80;
  localparam logic [7:0] D_ERA_GO   = 8'h10;
  localparam logic [7:0] D_LOCK_GO  = 8'h40;
  localparam logic [7:0] D_ID_ON    = 8'h90;
  localparam logic [7:0] D_ID_OFF   = 8'hF0;

endpackage

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ev_prog_o,
  output logic              ev_erase_o,
  output logic              ev_lock_o,
  output logic              ev_id_on_o,
  output logic              ev_id_off_o
);

  seq_state_e st_q, st_d;
  logic at_a, at_b;
  logic [7:0] d8;

  assign at_a = (addr_i[CMD_AW-1:0] == ADDR_KEY_A);
  assign at_b = (addr_i[CMD_AW-1:0] == ADDR_KEY_B);
  assign d8   = data_i[7:0];

  always_comb begin
    st_d        = st_q;
    ev_prog_o   = 1'b0;
    ev_erase_o  = 1'b0;
    ev_lock_o   = 1'b0;
    ev_id_on_o  = 1'b0;
    ev_id_off_o = 1'b0;
    if (fire_i) begin
      st_d = ST_IDLE;
      case (st_q)
        ST_IDLE: if (at_a && d8 == D_KEY_A) st_d = ST_KEY1;
        ST_KEY1: if (at_b && d8 == D_KEY_B) st_d = ST_KEY2;
        ST_KEY2: begin
          if (at_a) begin
            case (d8)
              D_PROG:    st_d = ST_PROG;
              D_ERA_SET: st_d = ST_ERA3;
              D_ID_ON:   ev_id_on_o = 1'b1;
              default:   st_d = ST_IDLE;
            endcase
          end
        end
        ST_PROG: ev_prog_o = 1'b1;
        ST_ERA3: if (at_a && d8 == D_KEY_A) st_d = ST_ERA4;
        ST_ERA4: if (at_b && d8 == D_KEY_B) st_d = ST_ERA5;
        ST_ERA5: begin
          if (at_a && d8 == D_ERA_GO)  ev_erase_o = 1'b1;
          if (at_a && d8 == D_LOCK_GO) ev_lock_o  = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
      // a lone exit byte works from every state but the program target
      if (st_q != ST_PROG && d8 == D_ID_OFF) ev_id_off_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/fcd_boot_guard.sv
module fcd_boot_guard #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned BOOT_LOG2 = 14,
  parameter bit          TOP_BOOT  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_set_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              locked_o,
  output logic              in_boot_o
);

  localparam int unsigned TAG_W = ADDR_W - BOOT_LOG2;

  logic [TAG_W-1:0] tag;
  logic lock_q;

  assign tag = chk_addr_i[ADDR_W-1:BOOT_LOG2];

  generate
    if (TOP_BOOT) begin : g_top
      assign in_boot_o = &tag;
    end else begin : g_bottom
      assign in_boot_o = ~|tag;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lock_q <= 1'b0;
    else if (lock_set_i) lock_q <= 1'b1;
  end

  assign locked_o = lock_q;

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned DATA_W   = 8,
  parameter logic [7:0]  MFR_CODE = 8'hA5,
  parameter logic [7:0]  DEV_CODE = 8'h3C
) (
  input  logic              id_mode_i,
  input  logic              locked_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);

  logic [DATA_W-1:0] id_byte;

  always_comb begin
    id_byte = '0;
    if (rd_addr_i == ADDR_W'(0))      id_byte = DATA_W'(MFR_CODE);
    else if (rd_addr_i == ADDR_W'(1)) id_byte = DATA_W'(DEV_CODE);
    else if (rd_addr_i == ADDR_W'(2)) id_byte = DATA_W'(locked_i);
  end

  assign rd_data_o = id_mode_i ? id_byte : arr_data_i;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BOOT_LOG2 = 14,
  parameter bit          TOP_BOOT  = 1'b0,
  parameter logic [7:0]  MFR_CODE  = 8'hA5,
  parameter logic [7:0]  DEV_CODE  = 8'h3C,
  parameter int unsigned RST_SYNC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              op_valid_o,
  output logic              op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              op_keep_boot_o,
  output logic              id_mode_o,
  output logic              boot_locked_o
);

  // reset: asserted at once, released after RST_SYNC clock edges
  logic [RST_SYNC-1:0] rst_sync_q;
  logic rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_SYNC-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[RST_SYNC-1];

  logic fire;
  logic ev_prog, ev_erase, ev_lock, ev_id_on, ev_id_off;
  logic locked, tgt_in_boot, prog_ok, op_fire;

  assign fire = wr_en_i & ~busy_i;

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .fire_i     (fire),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .ev_prog_o  (ev_prog),
    .ev_erase_o (ev_erase),
    .ev_lock_o  (ev_lock),
    .ev_id_on_o (ev_id_on),
    .ev_id_off_o(ev_id_off)
  );

  fcd_boot_guard #(.ADDR_W(ADDR_W), .BOOT_LOG2(BOOT_LOG2), .TOP_BOOT(TOP_BOOT)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .lock_set_i(ev_lock),
    .chk_addr_i(wr_addr_i),
    .locked_o  (locked),
    .in_boot_o (tgt_in_boot)
  );

  assign prog_ok = ev_prog & ~(locked & tgt_in_boot);
  assign op_fire = prog_ok | ev_erase;

  logic              valid_q, kind_q, keep_q, id_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      valid_q <= 1'b0;
      id_q    <= 1'b0;
    end else begin
      valid_q <= op_fire;
      if (ev_id_on)       id_q <= 1'b1;
      else if (ev_id_off) id_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      kind_q <= 1'b0;
      keep_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (op_fire) begin
      kind_q <= ev_erase;
      keep_q <= ev_erase & locked;
      addr_q <= ev_erase ? '0 : wr_addr_i;
      data_q <= ev_erase ? '1 : wr_data_i;
    end
  end

  fcd_read_mux #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_rmux (
    .id_mode_i (id_q),
    .locked_i  (locked),
    .rd_addr_i (rd_addr_i),
    .arr_data_i(arr_data_i),
    .rd_data_o (rd_data_o)
  );

  assign op_valid_o     = valid_q;
  assign op_kind_o      = kind_q;
  assign op_addr_o      = addr_q;
  assign op_data_o      = data_q;
  assign op_keep_boot_o = keep_q;
  assign id_mode_o      = id_q;
  assign boot_locked_o  = locked;

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned BOOT_LOG2 = 14,
  parameter bit          TOP_BOOT  = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] arr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              op_valid_o,
  input logic              op_kind_o,
  input logic [ADDR_W-1:0] op_addr_o,
  input logic              op_keep_boot_o,
  input logic              id_mode_o,
  input logic              boot_locked_o
);

  localparam longint WIN = 64'd1 << BOOT_LOG2;
  localparam longint TOP = 64'd1 << ADDR_W;

  logic tgt_boot;
  assign tgt_boot = TOP_BOOT ? (64'(op_addr_o) >= TOP - WIN) : (64'(op_addr_o) < WIN);

  AST_OP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |=> !op_valid_o); // R2

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_locked_o |=> boot_locked_o); // R4

  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> (!op_valid_o && $stable(id_mode_o) && $stable(boot_locked_o))); // R8

  AST_BOOT_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_kind_o && boot_locked_o) |-> !tgt_boot); // R10

  AST_ERASE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && op_kind_o) |-> (op_keep_boot_o == boot_locked_o)); // R3

  AST_ID_LOCK_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_mode_o && rd_addr_i == ADDR_W'(2)) |-> (rd_data_o == DATA_W'(boot_locked_o))); // R6

  AST_ARRAY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_mode_o |-> (rd_data_o == arr_data_i)); // R6

endmodule

bind flash_cmd_decoder fcd_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_LOG2(BOOT_LOG2), .TOP_BOOT(TOP_BOOT)
) u_fcd_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_i        (busy_i),
  .rd_addr_i     (rd_addr_i),
  .arr_data_i    (arr_data_i),
  .rd_data_o     (rd_data_o),
  .op_valid_o    (op_valid_o),
  .op_kind_o     (op_kind_o),
  .op_addr_o     (op_addr_o),
  .op_keep_boot_o(op_keep_boot_o),
  .id_mode_o     (id_mode_o),
  .boot_locked_o (boot_locked_o)
);

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  localparam logic [7:0] MFR = 8'hA5;
  localparam logic [7:0] DEV = 8'h3C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [18:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic [18:0] rd_addr = '0;
  logic [7:0]  arr_data = '0;
  logic [7:0]  rd_data;
  logic        op_valid, op_kind, op_keep, id_mode, locked;
  logic [18:0] op_addr;
  logic [7:0]  op_data;

  always #2.5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .rd_addr_i(rd_addr), .arr_data_i(arr_data),
    .rd_data_o(rd_data), .op_valid_o(op_valid), .op_kind_o(op_kind),
    .op_addr_o(op_addr), .op_data_o(op_data), .op_keep_boot_o(op_keep),
    .id_mode_o(id_mode), .boot_locked_o(locked)
  );

  int n_chk = 0, n_err = 0, n_ops = 0;
  bit done = 1'b0;
  logic        l_kind, l_keep;
  logic [18:0] l_addr;
  logic [7:0]  l_data;
  bit m_locked = 1'b0, m_id = 1'b0;

  always @(negedge clk) begin
    if (op_valid) begin
      n_ops++;
      l_kind = op_kind; l_addr = op_addr; l_data = op_data; l_keep = op_keep;
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic bit in_boot(logic [18:0] a);
    return a < 19'h04000;
  endfunction

  function automatic logic [7:0] exp_rd(logic [18:0] a, logic [7:0] arr);
    if (!m_id) return arr;
    if (a == 19'd0) return MFR;
    if (a == 19'd1) return DEV;
    if (a == 19'd2) return {7'd0, m_locked};
    return 8'h00;
  endfunction

  task automatic wr(logic [18:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [18:0] ka();
    return {4'($urandom), 15'h5555};
  endfunction
  function automatic logic [18:0] kb();
    return {4'($urandom), 15'h2AAA};
  endfunction

  task automatic check_rd(logic [18:0] a, string req);
    logic [7:0] arr;
    arr = 8'($urandom);
    rd_addr = a; arr_data = arr;
    #1;
    chk(rd_data == exp_rd(a, arr), req, rd_data, exp_rd(a, arr));
  endtask

  // kind: 0 program, 1 erase, 2 lock, 3 id on, 4 id off (3 writes), 5 id off (1 write)
  task automatic run_cmd(int kind, int corrupt, logic [18:0] tgt, logic [7:0] dat);
    logic [18:0] sa [6];
    logic [7:0]  sd [6];
    int n, ops0;
    bit expect_op;
    string req;
    n = 3;
    sa[0] = ka(); sd[0] = 8'hAA;
    sa[1] = kb(); sd[1] = 8'h55;
    sa[2] = ka();
    sa[3] = ka(); sd[3] = 8'hAA;
    sa[4] = kb(); sd[4] = 8'h55;
    sa[5] = ka();
    case (kind)
      0: begin sd[2] = 8'hA0; sa[3] = tgt; sd[3] = dat; n = 4; req = "R2"; end
      1: begin sd[2] = 8'h80; sd[5] = 8'h10; n = 6; req = "R3"; end
      2: begin sd[2] = 8'h80; sd[5] = 8'h40; n = 6; req = "R4"; end
      3: begin sd[2] = 8'h90; req = "R5"; end
      4: begin sd[2] = 8'hF0; req = "R5"; end
      default: begin sa[0] = tgt; sd[0] = 8'hF0; n = 1; req = "R5"; end
    endcase
    if (corrupt >= 0) req = "R7";
    ops0 = n_ops;
    for (int i = 0; i < n; i++) begin
      if (i == corrupt) begin
        wr(sa[i], sd[i] ^ 8'h01);
        break;
      end
      wr(sa[i], sd[i]);
    end
    @(negedge clk); #1;
    expect_op = 1'b0;
    if (corrupt < 0) begin
      case (kind)
        0: begin
          expect_op = !(m_locked && in_boot(tgt));
          if (m_locked && in_boot(tgt)) req = "R10";
        end
        1: expect_op = 1'b1;
        2: m_locked = 1'b1;
        3: m_id = 1'b1;
        default: m_id = 1'b0;
      endcase
    end
    chk((n_ops - ops0) == int'(expect_op), req, n_ops - ops0, int'(expect_op));
    if (expect_op) begin
      chk(l_kind == (kind == 1), req, l_kind, kind == 1);
      if (kind == 0) begin
        chk(l_addr == tgt, "R2", l_addr, tgt);
        chk(l_data == dat, "R2", l_data, dat);
      end else begin
        chk(l_keep == m_locked, "R3", l_keep, m_locked);
      end
    end
    chk(id_mode == m_id, req, id_mode, m_id);
    chk(locked == m_locked, req, locked, m_locked);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int ops0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(op_valid == 1'b0, "R1", op_valid, 0);
    chk(id_mode == 1'b0, "R1", id_mode, 0);
    chk(locked == 1'b0, "R1", locked, 0);
    check_rd(19'd0, "R1");

    // R2 directed program, R9 upper address bits set on the key writes
    run_cmd(0, -1, 19'h12345, 8'h3C);
    wr(19'h7D555, 8'hAA); wr(19'h42AAA, 8'h55); wr(19'h0D555, 8'hA0);
    ops0 = n_ops;
    wr(19'h00ABC, 8'h81);
    @(negedge clk); #1;
    chk(n_ops - ops0 == 1 && l_addr == 19'h00ABC, "R9", n_ops - ops0, 1);

    // R3 erase while unlocked
    run_cmd(1, -1, '0, '0);

    // R5/R6 identification mode and both exits
    run_cmd(3, -1, '0, '0);
    check_rd(19'd0, "R6"); check_rd(19'd1, "R6"); check_rd(19'd2, "R6");
    check_rd(19'h00007, "R6");
    run_cmd(5, -1, 19'h3BEEF, '0);
    check_rd(19'd1, "R6");
    run_cmd(3, -1, '0, '0);
    run_cmd(4, -1, '0, '0);

    // R8 busy masks a whole prefix and an ID entry
    busy = 1'b1;
    ops0 = n_ops;
    wr(ka(), 8'hAA); wr(kb(), 8'h55); wr(ka(), 8'h90);
    wr(ka(), 8'hAA); wr(kb(), 8'h55); wr(ka(), 8'hA0);
    busy = 1'b0;
    wr(19'h00300, 8'h5A);
    @(negedge clk); #1;
    chk(n_ops == ops0, "R8", n_ops - ops0, 0);
    chk(id_mode == 1'b0, "R8", id_mode, 0);

    // R7 mismatch then the rest of the broken sequence
    ops0 = n_ops;
    wr(ka(), 8'hAA); wr(kb(), 8'h55); wr(ka(), 8'h33);
    wr(ka(), 8'hA0); wr(19'h00100, 8'h77);
    @(negedge clk); #1;
    chk(n_ops == ops0, "R7", n_ops - ops0, 0);

    // R4 lockout, R10 window guard, R3 erase keeps boot
    run_cmd(2, -1, '0, '0);
    run_cmd(3, -1, '0, '0);
    check_rd(19'd2, "R4");
    run_cmd(5, -1, 19'd9, '0);
    run_cmd(0, -1, 19'h00100, 8'h11);
    run_cmd(0, -1, 19'h03FFF, 8'h12);
    run_cmd(0, -1, 19'h04000, 8'h13);
    run_cmd(1, -1, '0, '0);
    run_cmd(2, -1, '0, '0);

    // reset brings the lock back down for the random phase
    rst_n = 1'b0; m_locked = 1'b0; m_id = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(locked == 1'b0, "R1", locked, 0);

    for (int it = 0; it < 400; it++) begin
      int r, kind, cor, n;
      logic [18:0] tgt;
      r = $urandom_range(0, 99);
      if (r < 40) kind = 0; else if (r < 52) kind = 1; else if (r < 55) kind = 2;
      else if (r < 70) kind = 3; else if (r < 78) kind = 4; else kind = 5;
      n = (kind == 0) ? 4 : (kind == 1 || kind == 2) ? 6 : (kind == 5) ? 1 : 3;
      cor = -1;
      if ($urandom_range(0, 5) == 0) cor = $urandom_range(0, (kind == 0) ? 2 : n - 1);
      tgt = $urandom_range(0, 1) ? 19'($urandom_range(0, 16'h7FFF)) : 19'($urandom);
      run_cmd(kind, cor, tgt, 8'($urandom));
      check_rd($urandom_range(0, 1) ? 19'($urandom_range(0, 3)) : 19'($urandom), "R6");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule